// File: doc/BRIEF.md
# Line-Locked Numerically Controlled Clock-Enable Generator

This block is an all-digital phase-locked loop that runs entirely from one fast system clock. It takes a slow reference pulse, such as a video line-sync pulse, and produces a stream of single-cycle clock enables. The loop keeps the average rate of those enables at a fixed multiple of the reference rate. No clock is synthesised. The oscillator is a pulse-density modulator, and its enable is the block's output. The same enable also feeds the feedback divider.

The reference rising edges are divided by a programmable ratio (`ref_div_i`), and the generated enables by another (`fb_div_i`). A signed up/down error counter compares the two divided event streams. On a programmable decimation strobe, a proportional-plus-integral filter turns the error into an unsigned control word. A first-order accumulator then converts that word into enable density. In lock, the enable rate equals the reference rate times `fb_div_i / ref_div_i`. For example, a 15.625 kHz line rate with a feedback ratio of 1728 and a reference ratio of 1 gives a 27 MHz average enable. The system clock must be at least twice the target enable rate, and should be four times or more (for example 200 MHz for 27 MHz). Sources that mark the line on a falling edge must be inverted before they reach the block.

Top module: `nco_dpll`

## Requirements
- R1: Only a low-to-high transition of `ref_i` counts as a reference event. A level held high for many cycles counts once.
- R2: One divided-reference tick is produced per `ref_div_i` reference events. The values 0 and 1 both mean divide by one.
- R3: The error word `err_o` (two's complement, ERR_W bits) rises by one on a divided-reference tick and falls by one on a divided-feedback tick. It is unchanged when both ticks fall in the same cycle. It saturates at +2^(ERR_W-1)-1 and -2^(ERR_W-1), and never changes by more than one per cycle.
- R4: While the control word `ctrl_o` is zero, `nco_ce_o` stays low and the error word never falls.
- R5: While `ctrl_o` is all ones, `nco_ce_o` is high in every cycle.
- R6: One divided-feedback tick is produced per `fb_div_i` enables. At full-scale control, the error word therefore falls by one every `fb_div_i` cycles.
- R7: The loop updates once every `dec_rate_i`+1 cycles. `mon_vld_o` is high for exactly the one cycle after each update, and `ctrl_o` changes only in that cycle.
- R8: On each update, the integrator becomes integ + (err >>> `gain_i_i`). The control word becomes integ + (err >>> `gain_p_i`). Both are clamped to the range 0 to 2^CTRL_W-1, and the shifts are arithmetic.
- R9: While `hold_i` is high, the integrator keeps its value. The control word then follows only the proportional term.
- R10: After reset, `nco_ce_o`, `err_o`, `ctrl_o` and `mon_vld_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_i | input | 1 | Reference pulse, active on rising edge |
| ref_div_i | input | DIV_W | Reference divide ratio |
| fb_div_i | input | DIV_W | Feedback divide ratio |
| gain_p_i | input | GAIN_W | Proportional gain right shift |
| gain_i_i | input | GAIN_W | Integral gain right shift |
| dec_rate_i | input | DEC_W | Loop update period minus one |
| hold_i | input | 1 | Freeze the integrator |
| nco_ce_o | output | 1 | Generated clock enable |
| err_o | output | ERR_W | Signed phase/frequency error word |
| ctrl_o | output | CTRL_W | Unsigned control word |
| mon_vld_o | output | 1 | One-cycle strobe after each loop update |

## Verification
A divided-reference tick and a divided-feedback tick can land in the same cycle, and the error counter must then hold its value. The bench provokes this by driving the loop to full-scale control with a feedback ratio of one, so a feedback tick occurs in every cycle. It then injects reference pulses and requires the error to fall by the window length minus the number of pulses. A loop update can also coincide with an error step. The checker requires the control word to move only in the strobe cycle, and the error to move by at most one per cycle.

// File: rtl/nco_dpll_pkg.sv
// Package: default widths shared by the clock-enable loop and its bench.
// Assumes every width is at least 2 and ERR_W does not exceed CTRL_W.
package nco_dpll_pkg;
    localparam int DEF_DIV_W  = 16;
    localparam int DEF_ERR_W  = 12;
    localparam int DEF_CTRL_W = 16;
    localparam int DEF_GAIN_W = 4;
    localparam int DEF_DEC_W  = 16;
endpackage

// File: rtl/nco_dpll_div.sv
// Event divider: emits one tick per div_i input events; 0 and 1 pass all.
// Assumes div_i is held steady while it matters; a ratio lowered below
// the running count ends the current cycle on the next event.
module nco_dpll_div #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    logic [W-1:0] cnt_q;
    logic         last;

    // last event of the current division cycle
    always_comb begin
        last   = (div_i <= W'(1)) || (cnt_q >= div_i - W'(1));
        tick_o = evt_i && last;
    end

    // count events, restart after the terminal one
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (evt_i)
            cnt_q <= last ? '0 : cnt_q + W'(1);
    end
endmodule

// File: rtl/nco_dpll_pfd.sv
// Phase/frequency detector: saturating signed up/down counter of ticks.
// Assumes both ticks are single-cycle; coincident ticks cancel.
module nco_dpll_pfd #(
    parameter int ERR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    up_i,
    input  logic                    dn_i,
    output logic signed [ERR_W-1:0] err_o
);
    localparam logic signed [ERR_W-1:0] ERR_MAX = {1'b0, {(ERR_W-1){1'b1}}};
    localparam logic signed [ERR_W-1:0] ERR_MIN = {1'b1, {(ERR_W-1){1'b0}}};

    // step the error toward the leading side, holding at the limits
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_o <= '0;
        else if (up_i && !dn_i && err_o != ERR_MAX)
            err_o <= err_o + 1'b1;
        else if (dn_i && !up_i && err_o != ERR_MIN)
            err_o <= err_o - 1'b1;
    end
endmodule

// File: rtl/nco_dpll_filt.sv
// Loop filter: proportional-plus-integral update on a decimation strobe.
// Gains are right shifts; integrator and output clamp to the unsigned
// control range. Assumes ERR_W <= CTRL_W.
module nco_dpll_filt #(
    parameter int ERR_W  = 12,
    parameter int CTRL_W = 16,
    parameter int GAIN_W = 4,
    parameter int DEC_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ERR_W-1:0] err_i,
    input  logic [GAIN_W-1:0]       gain_p_i,
    input  logic [GAIN_W-1:0]       gain_i_i,
    input  logic [DEC_W-1:0]        dec_rate_i,
    input  logic                    hold_i,
    output logic [CTRL_W-1:0]       ctrl_o,
    output logic                    vld_o
);
    localparam int ACC_W = CTRL_W + 2;
    localparam logic signed [ACC_W-1:0] TOP = ACC_W'((64'd1 << CTRL_W) - 64'd1);

    logic [DEC_W-1:0]        dcnt_q;
    logic                    strobe;
    logic signed [ACC_W-1:0] integ_q, err_x, p_term, i_term, integ_sum, integ_nx, ctrl_sum;
    logic [CTRL_W-1:0]       ctrl_nx;

    // clamp a signed value to the unsigned control range
    function automatic logic signed [ACC_W-1:0] clamp(input logic signed [ACC_W-1:0] v);
        if (v < 0)
            return '0;
        else if (v > TOP)
            return TOP;
        else
            return v;
    endfunction

    // next integrator and control word
    always_comb begin
        strobe    = (dcnt_q >= dec_rate_i);
        err_x     = ACC_W'(err_i);
        p_term    = err_x >>> gain_p_i;
        i_term    = err_x >>> gain_i_i;
        integ_sum = integ_q + i_term;
        integ_nx  = hold_i ? integ_q : clamp(integ_sum);
        ctrl_sum  = integ_nx + p_term;
        ctrl_nx   = CTRL_W'(clamp(ctrl_sum));
    end

    // decimation counter sets the update period
    always_ff @(posedge clk) begin
        if (!rst_n)
            dcnt_q <= '0;
        else
            dcnt_q <= strobe ? '0 : dcnt_q + DEC_W'(1);
    end

    // filter state and the valid strobe that follows each update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            integ_q <= '0;
            ctrl_o  <= '0;
            vld_o   <= 1'b0;
        end else begin
            vld_o <= strobe;
            if (strobe) begin
                integ_q <= integ_nx;
                ctrl_o  <= ctrl_nx;
            end
        end
    end
endmodule

// File: rtl/nco_dpll_sdm.sv
// First-order pulse-density modulator: enable density = ctrl / (2^W - 1),
// so zero never fires and all-ones fires every cycle.
module nco_dpll_sdm #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ctrl_i,
    output logic         ce_o
);
    localparam logic [W:0] MODV = {1'b0, {W{1'b1}}};

    logic [W-1:0] acc_q;
    logic [W:0]   sum;
    logic         wrap;

    // accumulate and detect overflow past the modulus
    always_comb begin
        sum  = {1'b0, acc_q} + {1'b0, ctrl_i};
        wrap = (sum >= MODV);
    end

    // phase accumulator and registered enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            ce_o  <= 1'b0;
        end else begin
            acc_q <= wrap ? W'(sum - MODV) : sum[W-1:0];
            ce_o  <= wrap;
        end
    end
endmodule

// File: rtl/nco_dpll.sv
// Top: reference edge detect, two dividers, error counter, loop filter
// and pulse-density oscillator whose enable gates the feedback divider.
// Assumes ref_i is synchronous to clk and active on its rising edge.
module nco_dpll #(
    parameter int DIV_W  = nco_dpll_pkg::DEF_DIV_W,
    parameter int ERR_W  = nco_dpll_pkg::DEF_ERR_W,
    parameter int CTRL_W = nco_dpll_pkg::DEF_CTRL_W,
    parameter int GAIN_W = nco_dpll_pkg::DEF_GAIN_W,
    parameter int DEC_W  = nco_dpll_pkg::DEF_DEC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_i,
    input  logic [DIV_W-1:0]        ref_div_i,
    input  logic [DIV_W-1:0]        fb_div_i,
    input  logic [GAIN_W-1:0]       gain_p_i,
    input  logic [GAIN_W-1:0]       gain_i_i,
    input  logic [DEC_W-1:0]        dec_rate_i,
    input  logic                    hold_i,
    output logic                    nco_ce_o,
    output logic signed [ERR_W-1:0] err_o,
    output logic [CTRL_W-1:0]       ctrl_o,
    output logic                    mon_vld_o
);
    logic ref_q, ref_rise, ref_tick, fb_tick;

    // remember the previous reference level
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_q <= 1'b0;
        else
            ref_q <= ref_i;
    end

    // a reference event is a low-to-high transition
    always_comb ref_rise = ref_i && !ref_q;

    nco_dpll_div #(.W(DIV_W)) ref_div_u (
        .clk(clk), .rst_n(rst_n), .evt_i(ref_rise), .div_i(ref_div_i), .tick_o(ref_tick)
    );

    nco_dpll_div #(.W(DIV_W)) fb_div_u (
        .clk(clk), .rst_n(rst_n), .evt_i(nco_ce_o), .div_i(fb_div_i), .tick_o(fb_tick)
    );

    nco_dpll_pfd #(.ERR_W(ERR_W)) pfd_u (
        .clk(clk), .rst_n(rst_n), .up_i(ref_tick), .dn_i(fb_tick), .err_o(err_o)
    );

    nco_dpll_filt #(.ERR_W(ERR_W), .CTRL_W(CTRL_W), .GAIN_W(GAIN_W), .DEC_W(DEC_W)) filt_u (
        .clk(clk), .rst_n(rst_n), .err_i(err_o), .gain_p_i(gain_p_i), .gain_i_i(gain_i_i),
        .dec_rate_i(dec_rate_i), .hold_i(hold_i), .ctrl_o(ctrl_o), .vld_o(mon_vld_o)
    );

    nco_dpll_sdm #(.W(CTRL_W)) sdm_u (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_o), .ce_o(nco_ce_o)
    );
endmodule

// File: rtl/nco_dpll_chk.sv
// Checker: temporal properties of the loop ports, bound to nco_dpll.
module nco_dpll_chk #(
    parameter int ERR_W  = 12,
    parameter int CTRL_W = 16,
    parameter int DEC_W  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    nco_ce_o,
    input logic signed [ERR_W-1:0] err_o,
    input logic [CTRL_W-1:0]       ctrl_o,
    input logic                    mon_vld_o,
    input logic [DEC_W-1:0]        dec_rate_i
);
    AST_ZERO_CTRL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o == '0) |=> !nco_ce_o);                                                  // R4
    AST_FULL_CTRL_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o == '1) |=> nco_ce_o);                                                   // R5
    AST_ERR_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((err_o == $past(err_o)) || (err_o == $past(err_o) + 1'b1) || (err_o == $past(err_o) - 1'b1))); // R3
    AST_CTRL_MOVES_ON_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mon_vld_o && $past(rst_n)) |-> $stable(ctrl_o));                              // R7
    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_vld_o && dec_rate_i != '0) |=> !mon_vld_o);                                // R7
endmodule

bind nco_dpll nco_dpll_chk #(.ERR_W(ERR_W), .CTRL_W(CTRL_W), .DEC_W(DEC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .nco_ce_o(nco_ce_o), .err_o(err_o), .ctrl_o(ctrl_o),
    .mon_vld_o(mon_vld_o), .dec_rate_i(dec_rate_i)
);

// File: tb/nco_dpll_tb_top.sv
module nco_dpll_tb_top;
    localparam int DIV_W = 16, ERR_W = 12, CTRL_W = 16, GAIN_W = 4, DEC_W = 16;
    localparam int NVEC = 6;
    // each vector: ref ratio, pulse count, high length, expected error
    localparam int VEC [NVEC][4] = '{
        '{1, 5, 1, 5}, '{3, 7, 1, 2}, '{4, 8, 3, 2},
        '{0, 3, 1, 3}, '{2, 1, 6, 0}, '{1, 4, 10, 4}
    };

    logic clk = 1'b0, rst_n = 1'b0, ref_i = 1'b0, hold_i = 1'b0;
    logic [DIV_W-1:0] ref_div_i = 16'd1, fb_div_i = 16'd1000;
    logic [GAIN_W-1:0] gain_p_i = '0, gain_i_i = '0;
    logic [DEC_W-1:0] dec_rate_i = 16'hFFFF;
    logic nco_ce_o, mon_vld_o;
    logic signed [ERR_W-1:0] err_o;
    logic [CTRL_W-1:0] ctrl_o;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    nco_dpll #(.DIV_W(DIV_W), .ERR_W(ERR_W), .CTRL_W(CTRL_W), .GAIN_W(GAIN_W), .DEC_W(DEC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .ref_div_i(ref_div_i), .fb_div_i(fb_div_i),
        .gain_p_i(gain_p_i), .gain_i_i(gain_i_i), .dec_rate_i(dec_rate_i), .hold_i(hold_i),
        .nco_ce_o(nco_ce_o), .err_o(err_o), .ctrl_o(ctrl_o), .mon_vld_o(mon_vld_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulses(input int cnt, input int hi, input int lo);
        for (int i = 0; i < cnt; i++) begin
            ref_i = 1'b1;
            idle(hi);
            ref_i = 1'b0;
            idle(lo);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ref_i = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        int e0, vcnt, ce_seen;
        bit all_hi;
        @(negedge clk);
        idle(2);
        // R10: reset state
        chk(nco_ce_o == 0 && err_o == 0 && ctrl_o == 0 && mon_vld_o == 0, "R10 reset",
            int'(err_o) + int'(ctrl_o), 0);
        rst_n = 1'b1;
        idle(1);

        // table walk: edge detection and reference division with zero control
        for (int v = 0; v < NVEC; v++) begin
            ref_div_i  = DIV_W'(VEC[v][0]);
            dec_rate_i = 16'hFFFF;
            do_reset();
            ce_seen = 0;
            for (int p = 0; p < VEC[v][1]; p++) begin
                ref_i = 1'b1;
                for (int h = 0; h < VEC[v][2]; h++) begin @(negedge clk); ce_seen += nco_ce_o; end
                ref_i = 1'b0;
                for (int h = 0; h < 2; h++) begin @(negedge clk); ce_seen += nco_ce_o; end
            end
            idle(2);
            chk(int'(err_o) == VEC[v][3], $sformatf("R1 R2 R3 vector %0d", v), int'(err_o), VEC[v][3]);
            chk(ce_seen == 0 && ctrl_o == 0, "R4 zero control no enable", ce_seen, 0);
        end

        // hold freezes integrator, proportional path alone, update period
        ref_div_i = 16'd1; fb_div_i = 16'd1000; dec_rate_i = 16'd3;
        hold_i = 1'b1; gain_p_i = 4'd0; gain_i_i = 4'd0;
        do_reset();
        pulses(5, 1, 1);
        idle(20);
        chk(ctrl_o == 16'd5, "R9 hold ctrl equals error", int'(ctrl_o), 5);
        idle(40);
        chk(ctrl_o == 16'd5, "R9 hold ctrl stays", int'(ctrl_o), 5);
        pulses(3, 1, 1);
        gain_p_i = 4'd2;
        idle(12);
        chk(ctrl_o == 16'd2, "R8 proportional shift 8>>>2", int'(ctrl_o), 2);
        vcnt = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); vcnt += mon_vld_o; end
        chk(vcnt == 10, "R7 one strobe per four cycles", vcnt, 10);
        hold_i = 1'b0; gain_p_i = 4'd0;
        idle(40);
        chk(ctrl_o > 16'd40, "R8 integrator accumulates", int'(ctrl_o), 41);

        // saturation of error, then full-scale control
        hold_i = 1'b0; dec_rate_i = 16'hFFFF; fb_div_i = 16'd1000; ref_div_i = 16'd1;
        do_reset();
        pulses(2100, 1, 1);
        idle(2);
        chk(int'(err_o) == 2047, "R3 positive saturation", int'(err_o), 2047);
        dec_rate_i = 16'd3;
        idle(400);
        chk(ctrl_o == 16'hFFFF, "R8 control clamps at full scale", int'(ctrl_o), 65535);
        all_hi = 1;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (!nco_ce_o) all_hi = 0; end
        chk(all_hi, "R5 enable every cycle at full scale", int'(all_hi), 1);

        // feedback division at full scale
        fb_div_i = 16'd10;
        idle(20);
        e0 = int'(err_o);
        idle(100);
        chk(e0 - int'(err_o) == 10, "R6 ten feedback ticks in 100 cycles", e0 - int'(err_o), 10);

        // coincident reference and feedback ticks cancel
        fb_div_i = 16'd1;
        idle(5);
        e0 = int'(err_o);
        pulses(5, 1, 9);
        chk(e0 - int'(err_o) == 45, "R3 coincident ticks cancel", e0 - int'(err_o), 45);

        // run down: control clamps at zero and enables stop
        idle(6000);
        chk(ctrl_o == 16'd0, "R8 control clamps at zero", int'(ctrl_o), 0);
        chk(err_o < 0, "R3 error went negative", int'(err_o), -1);
        ce_seen = 0;
        e0 = int'(err_o);
        for (int i = 0; i < 50; i++) begin @(negedge clk); ce_seen += nco_ce_o; end
        chk(ce_seen == 0 && int'(err_o) == e0, "R4 no enable at zero control", ce_seen, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule